// File: doc/BRIEF.md
# Sequential Address and Interrupt Allocator

This block hands out address windows and interrupt numbers to devices that register one after another. An init operation loads a free-base pointer and a free-interrupt pointer. Each registration then asks for a base, a window size, a first interrupt and an interrupt count. A zero base or a zero first interrupt means "pick one for me". In that case the block grants the current free pointer and moves the pointer forward by the size or the count. A nonzero value is passed through unchanged.

After an interrupt grant, the free-interrupt pointer walks past a parameterised set of reserved interrupt numbers, one step per cycle. If the pointer then sits at or beyond the interrupt limit, a sticky overflow flag rises. While that flag is set, every request is refused until the next init. Requests arrive on a valid/ready handshake. The answer comes back as a one-cycle response strobe carrying the grants.

Top module: `rsrc_alloc`

## Requirements
- R1: After reset, reqReady is high, and rspValid, rspReject and overflow are low.
- R2: A request with reqBase equal to zero is granted the current free base, and the free base then grows by reqSize.
- R3: A request with a nonzero reqBase gets exactly that base back, and the free base is left as it was.
- R4: When reqIrq is zero and reqIrqCnt is above zero, the grant is the current free-interrupt value, and the pointer grows by reqIrqCnt.
- R5: When reqIrq is nonzero or reqIrqCnt is zero, rspIrq equals reqIrq, and the free-interrupt pointer does not move.
- R6: After an interrupt grant, the pointer is incremented once per cycle while it equals any entry of RSV_LIST. reqReady stays low for one cycle per increment plus one final check cycle. It stays low for no cycles at all when no interrupt was granted.
- R7: If, after the reserved-number skip, the pointer is greater than or equal to IRQ_MAX, overflow goes high.
- R8: overflow stays high until an init. A request accepted while it is high returns rspReject=1 with zero grants.
- R9: initValid loads the free base from initBase and the free interrupt from initIrq, and clears overflow. While initValid is high, reqReady is low.
- R10: rspValid is high in exactly the cycle after a handshake (reqValid and reqReady both high at a clock edge).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| initValid | input | 1 | Load pointers and clear overflow |
| initBase | input | ADDR_W | Start value for the free base |
| initIrq | input | IRQ_W | Start value for the free interrupt |
| reqValid | input | 1 | Registration request present |
| reqReady | output | 1 | Block can accept a request |
| reqBase | input | ADDR_W | Requested base, zero asks for allocation |
| reqSize | input | ADDR_W | Window size |
| reqIrq | input | IRQ_W | Requested first interrupt, zero asks for allocation |
| reqIrqCnt | input | IRQ_W | Number of interrupts |
| rspValid | output | 1 | Response strobe |
| rspReject | output | 1 | Request refused due to overflow |
| rspBase | output | ADDR_W | Granted base |
| rspIrq | output | IRQ_W | Granted first interrupt |
| overflow | output | 1 | Sticky interrupt-space overflow |

## Verification
The bench builds the block with a 16-bit address, an interrupt limit of 20, and reserved numbers 6, 11 and 12. With these values a short run of registrations lands on one isolated reserved number and on a pair of adjacent ones. The skip cycle count is therefore measurable as 0, 1, 2 and 3. A few more grants then push the pointer exactly to the limit. This makes overflow, rejection and recovery through init all reachable within a handful of requests.

// File: rtl/rsrc_alloc_pkg.sv
package rsrc_alloc_pkg;
  typedef enum logic {ST_IDLE, ST_SKIP} alloc_state_t;

  typedef struct packed {
    logic loadInit;
    logic takeReq;
    logic bumpIrq;
    logic setOvf;
  } alloc_strobe_t;
endpackage

// File: rtl/rsrc_alloc_ctrl.sv
module rsrc_alloc_ctrl
  import rsrc_alloc_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          initValid,
  input  logic          reqValid,
  input  logic          ovf,
  input  logic          irqAlloc,
  input  logic          rsvHit,
  input  logic          ptrOver,
  output logic          reqReady,
  output alloc_strobe_t strobe
);
  alloc_state_t state;

  assign reqReady = (state == ST_IDLE) && !initValid;

  always_comb begin
    strobe          = '0;
    strobe.loadInit = initValid;
    strobe.takeReq  = reqValid && reqReady;
    strobe.bumpIrq  = (state == ST_SKIP) && rsvHit && !initValid;
    strobe.setOvf   = (state == ST_SKIP) && !rsvHit && ptrOver && !initValid;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
    end else if (initValid) begin
      state <= ST_IDLE;
    end else begin
      case (state)
        ST_IDLE: if (strobe.takeReq && !ovf && irqAlloc) state <= ST_SKIP;
        ST_SKIP: if (!rsvHit) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rsrc_alloc_dp.sv
module rsrc_alloc_dp
  import rsrc_alloc_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int IRQ_W   = 8,
  parameter int IRQ_MAX = 64,
  parameter int NUM_RSV = 3,
  parameter logic [NUM_RSV*IRQ_W-1:0] RSV_LIST = {8'd34, 8'd33, 8'd32}
)(
  input  logic              clk,
  input  logic              rstN,
  input  alloc_strobe_t     strobe,
  input  logic [ADDR_W-1:0] initBase,
  input  logic [IRQ_W-1:0]  initIrq,
  input  logic [ADDR_W-1:0] reqBase,
  input  logic [ADDR_W-1:0] reqSize,
  input  logic [IRQ_W-1:0]  reqIrq,
  input  logic [IRQ_W-1:0]  reqIrqCnt,
  output logic              ovf,
  output logic              irqAlloc,
  output logic              rsvHit,
  output logic              ptrOver,
  output logic              rspValid,
  output logic              rspReject,
  output logic [ADDR_W-1:0] rspBase,
  output logic [IRQ_W-1:0]  rspIrq
);
  localparam int PTR_W = IRQ_W + 1;
  localparam logic [PTR_W-1:0] IRQ_LIM = PTR_W'(IRQ_MAX);

  logic [ADDR_W-1:0]  freeBase;
  logic [PTR_W-1:0]   freeIrq;
  logic [NUM_RSV-1:0] hitVec;

  for (genvar g = 0; g < NUM_RSV; g++) begin : g_rsv
    assign hitVec[g] = (freeIrq == {1'b0, RSV_LIST[g*IRQ_W +: IRQ_W]});
  end

  assign rsvHit   = |hitVec;
  assign ptrOver  = (freeIrq >= IRQ_LIM);
  assign irqAlloc = (reqIrq == '0) && (reqIrqCnt != '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      freeBase  <= '0;
      freeIrq   <= '0;
      ovf       <= 1'b0;
      rspValid  <= 1'b0;
      rspReject <= 1'b0;
      rspBase   <= '0;
      rspIrq    <= '0;
    end else begin
      rspValid <= strobe.takeReq;
      if (strobe.loadInit) begin
        freeBase <= initBase;
        freeIrq  <= {1'b0, initIrq};
        ovf      <= 1'b0;
      end else begin
        if (strobe.takeReq) begin
          if (ovf) begin
            rspReject <= 1'b1;
            rspBase   <= '0;
            rspIrq    <= '0;
          end else begin
            rspReject <= 1'b0;
            if (reqBase == '0) begin
              rspBase  <= freeBase;
              freeBase <= freeBase + reqSize;
            end else begin
              rspBase <= reqBase;
            end
            if (irqAlloc) begin
              rspIrq  <= freeIrq[IRQ_W-1:0];
              freeIrq <= freeIrq + {1'b0, reqIrqCnt};
            end else begin
              rspIrq <= reqIrq;
            end
          end
        end
        if (strobe.bumpIrq) freeIrq <= freeIrq + 1'b1;
        if (strobe.setOvf)  ovf     <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/rsrc_alloc.sv
module rsrc_alloc
  import rsrc_alloc_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int IRQ_W   = 8,
  parameter int IRQ_MAX = 64,
  parameter int NUM_RSV = 3,
  parameter logic [NUM_RSV*IRQ_W-1:0] RSV_LIST = {8'd34, 8'd33, 8'd32}
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic              initValid,
  input  logic [ADDR_W-1:0] initBase,
  input  logic [IRQ_W-1:0]  initIrq,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [ADDR_W-1:0] reqBase,
  input  logic [ADDR_W-1:0] reqSize,
  input  logic [IRQ_W-1:0]  reqIrq,
  input  logic [IRQ_W-1:0]  reqIrqCnt,
  output logic              rspValid,
  output logic              rspReject,
  output logic [ADDR_W-1:0] rspBase,
  output logic [IRQ_W-1:0]  rspIrq,
  output logic              overflow
);
  alloc_strobe_t strobe;
  logic irqAlloc, rsvHit, ptrOver;

  rsrc_alloc_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .initValid(initValid), .reqValid(reqValid),
    .ovf(overflow), .irqAlloc(irqAlloc), .rsvHit(rsvHit), .ptrOver(ptrOver),
    .reqReady(reqReady), .strobe(strobe)
  );

  rsrc_alloc_dp #(
    .ADDR_W(ADDR_W), .IRQ_W(IRQ_W), .IRQ_MAX(IRQ_MAX),
    .NUM_RSV(NUM_RSV), .RSV_LIST(RSV_LIST)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .initBase(initBase), .initIrq(initIrq),
    .reqBase(reqBase), .reqSize(reqSize), .reqIrq(reqIrq), .reqIrqCnt(reqIrqCnt),
    .ovf(overflow), .irqAlloc(irqAlloc), .rsvHit(rsvHit), .ptrOver(ptrOver),
    .rspValid(rspValid), .rspReject(rspReject), .rspBase(rspBase), .rspIrq(rspIrq)
  );
endmodule

// File: rtl/rsrc_alloc_chk.sv
module rsrc_alloc_chk #(
  parameter int ADDR_W = 32
)(
  input logic              clk,
  input logic              rstN,
  input logic              initValid,
  input logic              reqValid,
  input logic              reqReady,
  input logic [ADDR_W-1:0] reqBase,
  input logic              rspValid,
  input logic              rspReject,
  input logic [ADDR_W-1:0] rspBase,
  input logic              overflow
);
  // R10
  rsp_after_take_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> rspValid);
  // R10
  no_spur_rsp_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(reqValid && reqReady) |=> !rspValid);
  // R9
  init_blocks_ready_chk: assert property (@(posedge clk) disable iff (!rstN)
    initValid |-> !reqReady);
  // R9
  init_clears_ovf_chk: assert property (@(posedge clk) disable iff (!rstN)
    initValid |=> !overflow);
  // R8
  sticky_ovf_chk: assert property (@(posedge clk) disable iff (!rstN)
    (overflow && !initValid) |=> overflow);
  // R8
  reject_when_ovf_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady && overflow) |=> rspReject);
  // R3
  fixed_base_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady && !overflow && reqBase != '0) |=> (rspBase == $past(reqBase)));
endmodule

bind rsrc_alloc rsrc_alloc_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .initValid(initValid), .reqValid(reqValid),
  .reqReady(reqReady), .reqBase(reqBase), .rspValid(rspValid),
  .rspReject(rspReject), .rspBase(rspBase), .overflow(overflow)
);

// File: tb/rsrc_alloc_bench.sv
module rsrc_alloc_bench;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 16;
  localparam int IW = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic initValid = 1'b0;
  logic [AW-1:0] initBase = '0;
  logic [IW-1:0] initIrq = '0;
  logic reqValid = 1'b0;
  logic reqReady;
  logic [AW-1:0] reqBase = '0, reqSize = '0;
  logic [IW-1:0] reqIrq = '0, reqIrqCnt = '0;
  logic rspValid, rspReject, overflow;
  logic [AW-1:0] rspBase;
  logic [IW-1:0] rspIrq;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rsrc_alloc #(
    .ADDR_W(AW), .IRQ_W(IW), .IRQ_MAX(20), .NUM_RSV(3),
    .RSV_LIST({8'd12, 8'd11, 8'd6})
  ) u_rsrc_alloc (
    .clk(clk), .rstN(rstN), .initValid(initValid), .initBase(initBase),
    .initIrq(initIrq), .reqValid(reqValid), .reqReady(reqReady),
    .reqBase(reqBase), .reqSize(reqSize), .reqIrq(reqIrq), .reqIrqCnt(reqIrqCnt),
    .rspValid(rspValid), .rspReject(rspReject), .rspBase(rspBase),
    .rspIrq(rspIrq), .overflow(overflow)
  );

  typedef struct packed {
    logic [AW-1:0] base;
    logic [AW-1:0] size;
    logic [IW-1:0] irq;
    logic [IW-1:0] cnt;
    logic [AW-1:0] expBase;
    logic [IW-1:0] expIrq;
    logic [3:0]    expBusy;
  } vec_t;

  // init base 0x1000, irq 2; reserved 6, 11, 12
  localparam vec_t VECS [7] = '{
    '{16'h0000, 16'h0100, 8'd0, 8'd2, 16'h1000, 8'd2,  4'd1},  // R2 R4
    '{16'h8000, 16'h0040, 8'd0, 8'd1, 16'h8000, 8'd4,  4'd1},  // R3
    '{16'h0000, 16'h0020, 8'd0, 8'd1, 16'h1100, 8'd5,  4'd2},  // R6 one skip
    '{16'h0000, 16'h0010, 8'd9, 8'd3, 16'h1120, 8'd9,  4'd0},  // R5 fixed irq
    '{16'h0000, 16'h0010, 8'd0, 8'd0, 16'h1130, 8'd0,  4'd0},  // R5 zero count
    '{16'h0000, 16'h0000, 8'd0, 8'd4, 16'h1140, 8'd7,  4'd3},  // R6 two skips
    '{16'h0000, 16'h0008, 8'd0, 8'd1, 16'h1140, 8'd13, 4'd1}   // R4 after skips
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic doReq(input logic [AW-1:0] b, input logic [AW-1:0] s,
                       input logic [IW-1:0] i, input logic [IW-1:0] c,
                       output logic rej, output logic [AW-1:0] gb,
                       output logic [IW-1:0] gi, output int busy);
    @(negedge clk);
    while (!reqReady) @(negedge clk);
    reqBase = b; reqSize = s; reqIrq = i; reqIrqCnt = c; reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    check("R10 rspValid", {31'd0, rspValid}, 32'd1);
    rej = rspReject; gb = rspBase; gi = rspIrq;
    busy = 0;
    while (!reqReady && busy < 20) begin
      busy++;
      @(negedge clk);
    end
  endtask

  task automatic doInit(input logic [AW-1:0] b, input logic [IW-1:0] i);
    @(negedge clk);
    initBase = b; initIrq = i; initValid = 1'b1;
    #1;
    check("R9 ready low during init", {31'd0, reqReady}, 32'd0);
    @(negedge clk);
    initValid = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD*2000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic rej;
    logic [AW-1:0] gb;
    logic [IW-1:0] gi;
    int busy;

    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 reqReady", {31'd0, reqReady}, 32'd1);
    check("R1 rspValid", {31'd0, rspValid}, 32'd0);
    check("R1 rspReject", {31'd0, rspReject}, 32'd0);
    check("R1 overflow", {31'd0, overflow}, 32'd0);

    doInit(16'h1000, 8'd2);

    for (int k = 0; k < 7; k++) begin
      doReq(VECS[k].base, VECS[k].size, VECS[k].irq, VECS[k].cnt, rej, gb, gi, busy);
      check("R2/R3 base", {16'd0, gb}, {16'd0, VECS[k].expBase});
      check("R4/R5 irq", {24'd0, gi}, {24'd0, VECS[k].expIrq});
      check("R6 busy cycles", busy, {28'd0, VECS[k].expBusy});
      check("R8 no reject", {31'd0, rej}, 32'd0);
    end
    // R7 pointer at 14, below limit
    check("R7 no overflow yet", {31'd0, overflow}, 32'd0);

    // R7 push pointer to exactly 20
    doReq(16'h0, 16'h4, 8'd0, 8'd6, rej, gb, gi, busy);
    check("R4 irq grant", {24'd0, gi}, 32'd14);
    check("R2 base grant", {16'd0, gb}, 32'h1148);
    check("R7 overflow set", {31'd0, overflow}, 32'd1);

    // R8 rejected while overflowed
    doReq(16'h0, 16'h4, 8'd0, 8'd1, rej, gb, gi, busy);
    check("R8 reject", {31'd0, rej}, 32'd1);
    check("R8 zero base", {16'd0, gb}, 32'd0);
    check("R8 zero irq", {24'd0, gi}, 32'd0);
    check("R8 sticky", {31'd0, overflow}, 32'd1);

    // R9 re-init clears and reloads
    doInit(16'h2000, 8'd5);
    check("R9 overflow cleared", {31'd0, overflow}, 32'd0);
    doReq(16'h0, 16'h10, 8'd0, 8'd1, rej, gb, gi, busy);
    check("R9 base reload", {16'd0, gb}, 32'h2000);
    check("R9 irq reload", {24'd0, gi}, 32'd5);
    check("R6 skip after init", busy, 32'd2);
    doReq(16'h0, 16'h10, 8'd0, 8'd1, rej, gb, gi, busy);
    check("R6 skipped reserved 6", {24'd0, gi}, 32'd7);
    check("R2 base advanced", {16'd0, gb}, 32'h2010);
    @(negedge clk);
    check("R10 strobe one cycle", {31'd0, rspValid}, 32'd0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule